// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Transmitter

This block drives a stereo serial audio link as clock master. It divides the system clock down to a bit clock. It produces the word-select line and shifts one left and one right sample per frame out on a single data line. Each sample is 24 bits, and the upper bits of the field are the significant ones.

A 2-bit format code picks how a word sits inside its 32-bit channel slot. One choice puts the MSB one bit clock after the word-select edge. The other three (16, 20 or 24 bits) right-align the word so that its LSB ends the slot.

A new sample pair and the format code are both taken at the bit-clock falling edge that opens a left slot. A one-cycle strobe acknowledges the pair. If no pair is offered at that edge, the previous pair is sent again.

Top module: `audio_ser_tx`

## Requirements
- R1: While rst_n is low, bck, ws, sdata and smp_taken are all 0. The first bck falling edge after reset comes 2*DIV_HALF enabled clocks later and opens a left slot.
- R2: With en high, bck is a square wave of period 2*DIV_HALF clk cycles. With en low, bck, ws and sdata hold their values and the frame does not advance.
- R3: A frame is 64 bck periods: 32 with ws = 0 (left slot) followed by 32 with ws = 1 (right slot).
- R4: ws and sdata change only at clk edges where bck falls, so a receiver can sample both on bck rising.
- R5: Format code 2'b00 places the 24-bit sample MSB first in slot periods 1 to 24, with period 0 counted from the ws edge. All other periods of the slot carry 0.
- R6: Format codes 2'b01, 2'b10 and 2'b11 send the upper 16, 20 or 24 sample bits MSB first, ending with that word's LSB in slot period 31. The earlier periods of the slot carry 0.
- R7: At the bck falling edge that opens a left slot, if smp_valid is high, smp_left and smp_right are captured and smp_taken is high for exactly one clk cycle. That frame carries the captured pair.
- R8: If smp_valid is low at that edge, smp_taken stays low and the frame repeats the previously captured pair.
- R9: fmt is sampled only at the left-slot opening edge. A change during a frame does not alter that frame and applies from the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Clock enable for bit-clock generation |
| fmt | input | 2 | Format code: 00 I2S, 01/10/11 right-justified 16/20/24 bits |
| smp_valid | input | 1 | A sample pair is offered |
| smp_left | input | 24 | Left sample, MSB-aligned |
| smp_right | input | 24 | Right sample, MSB-aligned |
| smp_taken | output | 1 | One-cycle strobe: pair captured |
| bck | output | 1 | Bit clock |
| ws | output | 1 | Word select, 0 = left, 1 = right |
| sdata | output | 1 | Serial data |

## Verification
Two things happen on the same bck falling edge: a new sample pair is captured and a new format code takes effect. The bench changes both together between table rows and compares each slot of the frame after the strobe with a bit pattern computed from the new code and the new pair. It also changes the code in the middle of a frame, and then expects the current frame to keep the old placement while the next frame uses the new one.

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [1:0]  fmt,
  input  logic        smp_valid,
  input  logic [23:0] smp_left,
  input  logic [23:0] smp_right,
  output logic        smp_taken,
  output logic        bck,
  output logic        ws,
  output logic        sdata
);
  localparam int HC_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int WORD = 24;
  localparam int POS_W = 5;
  localparam int FRM_W = POS_W + 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(DIV_HALF - 1);

  logic [HC_W-1:0]  hcnt;
  logic [FRM_W-1:0] bidx, nidx;
  logic [POS_W-1:0] pos;
  logic [1:0]       fmt_q;
  logic [WORD-1:0]  shd_l, shd_r, cur;
  logic [5:0]       st, wd, k;
  logic             tick, fall, in_rng, bit_nx;

  assign tick = en && (hcnt == HC_LAST);
  assign fall = tick && bck;
  assign nidx = bidx + 1'b1;
  assign pos  = nidx[POS_W-1:0];
  assign cur  = nidx[POS_W] ? shd_r : shd_l;

  always_comb begin
    case (fmt_q)
      2'b00:   begin st = 6'd1;  wd = 6'd24; end
      2'b01:   begin st = 6'd16; wd = 6'd16; end
      2'b10:   begin st = 6'd12; wd = 6'd20; end
      default: begin st = 6'd8;  wd = 6'd24; end
    endcase
  end

  assign k      = {1'b0, pos} - st;
  assign in_rng = ({1'b0, pos} >= st) && (k < wd);
  assign bit_nx = in_rng & cur[5'd23 - k[4:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt      <= '0;
      bck       <= 1'b0;
      ws        <= 1'b0;
      sdata     <= 1'b0;
      bidx      <= '1;
      fmt_q     <= 2'b00;
      shd_l     <= '0;
      shd_r     <= '0;
      smp_taken <= 1'b0;
    end else begin
      smp_taken <= 1'b0;
      if (en) hcnt <= tick ? '0 : hcnt + 1'b1;
      if (tick) bck <= ~bck;
      if (fall) begin
        bidx  <= nidx;
        ws    <= nidx[POS_W];
        sdata <= bit_nx;
        if (nidx == '0) begin
          fmt_q <= fmt;
          if (smp_valid) begin
            shd_l     <= smp_left;
            shd_r     <= smp_right;
            smp_taken <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic smp_valid,
  input logic smp_taken,
  input logic bck,
  input logic ws,
  input logic sdata
);
  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> $fell(bck)); // R4
  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $fell(bck)); // R4
  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(bck) && $stable(ws) && $stable(sdata)); // R2
  AST_TAKE_AT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    smp_taken |-> $fell(bck) && !ws); // R7
  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_taken |=> !smp_taken); // R7
  AST_TAKE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    smp_taken |-> $past(smp_valid)); // R8
endmodule

bind audio_ser_tx audio_ser_tx_chk u_chk (.*);

// File: tb/sim_audio_ser_tx.sv
module sim_audio_ser_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic [1:0] fmt = 2'b00;
  logic smp_valid = 1'b0;
  logic [23:0] smp_left = '0, smp_right = '0;
  logic smp_taken, bck, ws, sdata;

  always #4 clk = ~clk;

  audio_ser_tx #(.DIV_HALF(2)) u0 (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [49:0] VEC [8] = '{
    {2'b00, 24'hA5F00F, 24'h5A0FF0},
    {2'b01, 24'h123456, 24'hABCDEF},
    {2'b10, 24'h800001, 24'h7FFFFE},
    {2'b11, 24'hC3C3C3, 24'h3C3C3C},
    {2'b00, 24'hFFFFFF, 24'h000001},
    {2'b01, 24'hFFFFFF, 24'hFFFFFF},
    {2'b10, 24'h000000, 24'hFFFFFF},
    {2'b11, 24'h800000, 24'h000001}
  };

  // monitor: capture slots at bck rise, watch edge discipline
  logic [31:0] acc, lcap, rcap;
  int pos = 0, llen = 0, rlen = 0, slot_cnt = 0, taken_cnt = 0, viol = 0;
  int cyc = 0, last_rise = 0, bck_per = 0;
  logic bck_p = 0, ws_p = 0, sd_p = 0, ws_slot = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (smp_taken) taken_cnt++;
      if (!(bck_p && !bck) && (ws !== ws_p || sdata !== sd_p)) viol++;
      if (bck && !bck_p) begin
        bck_per = cyc - last_rise;
        last_rise = cyc;
        if (ws !== ws_slot) begin
          if (ws_slot) begin rcap = acc; rlen = pos; end
          else begin lcap = acc; llen = pos; end
          slot_cnt++;
          pos = 0;
          acc = '0;
        end
        if (pos < 32) acc[pos] = sdata;
        pos++;
        ws_slot = ws;
      end
    end
    bck_p = bck; ws_p = ws; sd_p = sdata;
  end

  function automatic logic [31:0] exp_slot(input logic [1:0] f, input logic [23:0] s);
    logic [31:0] v = '0;
    int n, first;
    n = (f == 2'b01) ? 16 : (f == 2'b10) ? 20 : 24;
    first = (f == 2'b00) ? 1 : 32 - n;
    for (int i = 0; i < n; i++) v[first + i] = s[23 - i];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_slots(input int target);
    while (slot_cnt < target) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [1:0] f, input logic [23:0] l, input logic [23:0] r);
    int s0;
    @(negedge clk);
    fmt = f; smp_left = l; smp_right = r; smp_valid = 1'b1;
    do @(negedge clk); while (!smp_taken);
    s0 = slot_cnt;
    wait_slots(s0 + 3);
    chk(lcap === exp_slot(f, l), "R5/R6/R7 left slot", lcap, exp_slot(f, l));
    chk(rcap === exp_slot(f, r), "R5/R6/R7 right slot", rcap, exp_slot(f, r));
    chk(llen == 32 && rlen == 32, "R3 slot length", 32'(llen), 32);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      summary();
    end
  end

  initial begin
    int s0, t0;
    logic [31:0] snap;
    repeat (5) @(negedge clk);
    chk({bck, ws, sdata, smp_taken} === 4'b0, "R1 reset outputs", {28'b0, bck, ws, sdata, smp_taken}, 0);
    rst_n = 1'b1;
    // R1: first falling edge opens a left slot after 4 clocks
    repeat (4) @(negedge clk);
    chk(!bck && !ws, "R1 first fall", {30'b0, bck, ws}, 0);

    for (int i = 0; i < 8; i++) run_vec(VEC[i][49:48], VEC[i][47:24], VEC[i][23:0]);

    chk(bck_per == 4, "R2 bck period", 32'(bck_per), 4);

    // R2: freeze with en low
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    snap = {29'b0, bck, ws, sdata};
    t0 = 0;
    repeat (20) begin
      @(negedge clk);
      if ({29'b0, bck, ws, sdata} !== snap) t0++;
    end
    chk(t0 == 0, "R2 frozen with en low", 32'(t0), 0);
    en = 1'b1;

    // R8: no valid at frame start -> old pair repeated, no strobe
    run_vec(2'b11, 24'h13579B, 24'h2468AC);
    smp_valid = 1'b0; smp_left = 24'hFFFFFF; smp_right = 24'h000000;
    t0 = taken_cnt; s0 = slot_cnt;
    wait_slots(s0 + 4);
    chk(taken_cnt == t0, "R8 no strobe", 32'(taken_cnt - t0), 0);
    chk(lcap === exp_slot(2'b11, 24'h13579B), "R8 left repeated", lcap, exp_slot(2'b11, 24'h13579B));
    chk(rcap === exp_slot(2'b11, 24'h2468AC), "R8 right repeated", rcap, exp_slot(2'b11, 24'h2468AC));

    // R9: format change mid-frame applies next frame
    run_vec(2'b01, 24'h9ABCDE, 24'h6789AB);
    fmt = 2'b00;
    s0 = slot_cnt;
    wait_slots(s0 + 2);
    chk(lcap === exp_slot(2'b01, 24'h9ABCDE), "R9 current frame keeps old format", lcap, exp_slot(2'b01, 24'h9ABCDE));
    wait_slots(s0 + 4);
    chk(lcap === exp_slot(2'b00, 24'h9ABCDE), "R9 next frame new format", lcap, exp_slot(2'b00, 24'h9ABCDE));
    chk(rcap === exp_slot(2'b00, 24'h6789AB), "R9 next frame right", rcap, exp_slot(2'b00, 24'h6789AB));

    chk(viol == 0, "R4 ws/sdata only on bck fall", 32'(viol), 0);
    done = 1'b1;
    summary();
  end
endmodule